// File: doc/BRIEF.md
# Serial EEPROM Device Model (Microwire)

This block is a synthesizable model of a small serial EEPROM. The memory holds 64 words of 16 bits. It sits on a four-wire Microwire link made of chip select, serial clock, serial data in and serial data out.

The block runs on a system clock. It samples the serial pins into that clock domain and acts on each low-to-high transition of the serial clock. While chip select is high, a host clocks in the following fields, MSB first:

- a start bit of 1;
- a 2-bit opcode;
- a 6-bit address;
- for write commands, 16 data bits.

The block decodes all seven commands: read, write, erase, erase-all, write-all, program-enable and program-disable. Read data goes back on the data out pin. The storage is a register array that reset clears. A program-enable latch guards every command that changes the array.

Top module: `mwEeprom`

## Requirements
- R1: After reset every word reads as 0x0000, programming is disabled, and `serDout` is high.
- R2: While chip select is high, serial clock rises that sample a 0 before any start bit are ignored. The command begins at the first sampled 1.
- R3: Opcode 10 (read): the rising edge that samples the last address bit makes `serDout` show a 0. Each later rising edge then presents the next stored bit, from bit 15 down to bit 0.
- R4: Opcode 01 (write) stores the 16 data bits that follow the address, first bit into bit 15. The store happens only once all 16 bits are in, and only while programming is enabled.
- R5: Opcode 11 (erase) sets the addressed word to 0xFFFF while programming is enabled.
- R6: Opcode 00 with address bits [5:4] = 10 (erase-all) sets every word to 0xFFFF while programming is enabled.
- R7: Opcode 00 with address bits [5:4] = 01 (write-all) writes the 16 following data bits to every word while programming is enabled.
- R8: Opcode 00 with address bits [5:4] = 11 enables programming, and with 00 disables it. Address bits [3:0] are don't-care. While programming is disabled, write, erase, erase-all and write-all leave the array unchanged.
- R9: Dropping chip select at any point ends the command. A partly received write stores nothing, and the next command needs a fresh start bit.
- R10: `serDout` is high whenever no read is in progress. This covers command entry, the edge after bit 0 has been shown, and any time chip select is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| chipSel | input | 1 | Chip select, active high |
| serClk | input | 1 | Serial clock; acts on rising transitions |
| serDin | input | 1 | Serial command, address and data in |
| serDout | output | 1 | Serial read data out, idle high |

## Verification
The bench checks the read framing bit by bit. A design that skips the dummy zero, or shifts one edge early or late, shows every bit of the word in the wrong slot.

It sends program commands while programming is disabled and then reads the words back. A design with a leaky enable gate shows altered contents.

It drops chip select partway through a write and partway through a read. A design that commits on partial data, or keeps driving read bits, shows the wrong word or a low `serDout`.

Leading zeros before the start bit test that the shifter does not latch the command one position off.

// File: rtl/mwEepromPkg.sv
package mwEepromPkg;
  localparam int MW_ADDR_W = 6;
  localparam int MW_DATA_W = 16;

  localparam logic [1:0] OP_MISC  = 2'b00;
  localparam logic [1:0] OP_WRITE = 2'b01;
  localparam logic [1:0] OP_READ  = 2'b10;
  localparam logic [1:0] OP_ERASE = 2'b11;

  localparam logic [1:0] SUB_DIS  = 2'b00;
  localparam logic [1:0] SUB_WRAL = 2'b01;
  localparam logic [1:0] SUB_ERAL = 2'b10;
  localparam logic [1:0] SUB_EN   = 2'b11;

  typedef enum logic [2:0] {S_IDLE, S_CMD, S_DATA, S_READ, S_DONE} mwState_e;

  typedef struct packed {
    logic shiftData;
    logic loadRead;
    logic shiftOut;
    logic readActive;
    logic doWrite;
    logic doErase;
    logic doEraseAll;
    logic doWriteAll;
    logic setEn;
    logic clrEn;
  } mwStrobe_t;
endpackage

// File: rtl/mwEepromCtrl.sv
module mwEepromCtrl
  import mwEepromPkg::*;
#(
  parameter int ADDR_W = MW_ADDR_W,
  parameter int DATA_W = MW_DATA_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              chipSel,
  input  logic              serClk,
  input  logic              serDin,
  output mwStrobe_t         stb,
  output logic [ADDR_W-1:0] addr,
  output logic              dinQ
);
  localparam int CMD_W = ADDR_W + 2;
  localparam int CNT_W = $clog2(DATA_W + 1);

  logic csQ, sclkQ, sclkPrev, rise;
  mwState_e state, nextState;
  logic [CNT_W-1:0] cnt, nextCnt;
  logic [CMD_W-1:0] cmdSh, full;
  logic [1:0] opFull, subFull;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csQ <= 1'b0; sclkQ <= 1'b0; sclkPrev <= 1'b0; dinQ <= 1'b0;
    end else begin
      csQ <= chipSel; sclkQ <= serClk; sclkPrev <= sclkQ; dinQ <= serDin;
    end
  end

  assign rise    = sclkQ & ~sclkPrev;
  assign full    = {cmdSh[CMD_W-2:0], dinQ};
  assign opFull  = full[CMD_W-1:CMD_W-2];
  assign subFull = full[ADDR_W-1:ADDR_W-2];

  always_comb begin
    stb = '0;
    nextState = state;
    nextCnt = cnt;
    stb.readActive = (state == S_READ);
    addr = (state == S_CMD) ? full[ADDR_W-1:0] : cmdSh[ADDR_W-1:0];
    if (!csQ) begin
      nextState = S_IDLE;
      nextCnt = '0;
    end else if (rise) begin
      case (state)
        S_IDLE: if (dinQ) begin nextState = S_CMD; nextCnt = '0; end
        S_CMD: begin
          nextCnt = cnt + 1'b1;
          if (cnt == CNT_W'(CMD_W - 1)) begin
            nextCnt = '0;
            nextState = S_DONE;
            case (opFull)
              OP_READ:  begin stb.loadRead = 1'b1; nextState = S_READ; end
              OP_WRITE: nextState = S_DATA;
              OP_ERASE: stb.doErase = 1'b1;
              default: begin
                case (subFull)
                  SUB_EN:   stb.setEn = 1'b1;
                  SUB_ERAL: stb.doEraseAll = 1'b1;
                  SUB_WRAL: nextState = S_DATA;
                  default:  stb.clrEn = 1'b1;
                endcase
              end
            endcase
          end
        end
        S_DATA: begin
          stb.shiftData = 1'b1;
          nextCnt = cnt + 1'b1;
          if (cnt == CNT_W'(DATA_W - 1)) begin
            nextState = S_DONE;
            nextCnt = '0;
            if (cmdSh[CMD_W-1:CMD_W-2] == OP_WRITE) stb.doWrite = 1'b1;
            else stb.doWriteAll = 1'b1;
          end
        end
        S_READ: begin
          if (cnt == CNT_W'(DATA_W)) nextState = S_DONE;
          else begin stb.shiftOut = 1'b1; nextCnt = cnt + 1'b1; end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
      cnt   <= '0;
      cmdSh <= '0;
    end else begin
      state <= nextState;
      cnt   <= nextCnt;
      if (csQ && rise && state == S_CMD) cmdSh <= full;
    end
  end

  // R2: a sampled 0 before the start bit keeps the shifter idle
  p_lead_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    (csQ && rise && state == S_IDLE && !dinQ) |=> state == S_IDLE);

  // R9: chip select low always returns the sequencer to idle
  p_cs_abort_r9: assert property (@(posedge clk) disable iff (!rstN)
    !csQ |=> state == S_IDLE);

  // R8: at most one array or latch action per edge
  p_one_action_r8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.doWrite, stb.doErase, stb.doEraseAll, stb.doWriteAll, stb.setEn, stb.clrEn}));
endmodule

// File: rtl/mwEepromDatapath.sv
module mwEepromDatapath
  import mwEepromPkg::*;
#(
  parameter int ADDR_W = MW_ADDR_W,
  parameter int DATA_W = MW_DATA_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  mwStrobe_t         stb,
  input  logic [ADDR_W-1:0] addr,
  input  logic              dinQ,
  output logic              serDout
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-2:0] dataSh;
  logic [DATA_W-1:0] wrWord, selWord;
  logic [DATA_W:0]   outSh;
  logic              progEn;

  assign wrWord  = {dataSh, dinQ};
  assign selWord = mem[addr];

  for (genvar w = 0; w < DEPTH; w++) begin : g_word
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) mem[w] <= '0;
      else if (progEn) begin
        if (stb.doEraseAll) mem[w] <= '1;
        else if (stb.doWriteAll) mem[w] <= wrWord;
        else if (addr == ADDR_W'(w)) begin
          if (stb.doErase) mem[w] <= '1;
          else if (stb.doWrite) mem[w] <= wrWord;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      progEn <= 1'b0;
      dataSh <= '0;
      outSh  <= '1;
    end else begin
      if (stb.setEn) progEn <= 1'b1;
      else if (stb.clrEn) progEn <= 1'b0;
      if (stb.shiftData) dataSh <= wrWord[DATA_W-2:0];
      if (stb.loadRead) outSh <= {1'b0, selWord};
      else if (stb.shiftOut) outSh <= {outSh[DATA_W-1:0], 1'b1};
    end
  end

  assign serDout = stb.readActive ? outSh[DATA_W] : 1'b1;

  // R3: the first bit shown after a read command is a dummy zero
  p_dummy_zero_r3: assert property (@(posedge clk) disable iff (!rstN)
    stb.loadRead |=> !outSh[DATA_W]);

  // R8: with programming disabled the addressed word does not move
  p_locked_word_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!progEn && (stb.doWrite || stb.doErase)) |=> $stable(selWord));

  // R5: an enabled erase leaves the addressed word all ones
  p_erase_ones_r5: assert property (@(posedge clk) disable iff (!rstN)
    (progEn && stb.doErase) |=> selWord == '1);

  // R6: an enabled erase-all sets the first and last words to all ones
  p_erase_all_r6: assert property (@(posedge clk) disable iff (!rstN)
    (progEn && stb.doEraseAll) |=> (mem[0] == '1 && mem[DEPTH-1] == '1));
endmodule

// File: rtl/mwEeprom.sv
module mwEeprom
  import mwEepromPkg::*;
#(
  parameter int ADDR_W = MW_ADDR_W,
  parameter int DATA_W = MW_DATA_W
) (
  input  logic clk,
  input  logic rstN,
  input  logic chipSel,
  input  logic serClk,
  input  logic serDin,
  output logic serDout
);
  mwStrobe_t         stb;
  logic [ADDR_W-1:0] addr;
  logic              dinQ;

  mwEepromCtrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .chipSel(chipSel), .serClk(serClk),
    .serDin(serDin), .stb(stb), .addr(addr), .dinQ(dinQ)
  );

  mwEepromDatapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .addr(addr), .dinQ(dinQ),
    .serDout(serDout)
  );
endmodule

// File: tb/mwEeprom_bench.sv
`timescale 1ns/1ps
module mwEeprom_bench;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic chipSel = 1'b0, serClk = 1'b0, serDin = 1'b0;
  logic serDout;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  logic [15:0] refMem [64];
  bit refEn = 1'b0;

  always #10 clk = ~clk;

  mwEeprom u_mwEeprom (.clk(clk), .rstN(rstN), .chipSel(chipSel),
    .serClk(serClk), .serDin(serDin), .serDout(serDout));

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input logic got, input logic exp, input string req);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s: serDout=%0b expected %0b", req, got, exp);
    end
  endtask

  task automatic bitCycle(input logic b, input logic expOut, input string req);
    serDin = b;
    tick(HALF);
    chk(serDout, expOut, req);
    serClk = 1'b1;
    tick(HALF);
    serClk = 1'b0;
  endtask

  task automatic header(input logic [1:0] op, input logic [5:0] a, input int lead);
    chipSel = 1'b1;
    tick(2);
    for (int i = 0; i < lead; i++) bitCycle(1'b0, 1'b1, "R2");
    bitCycle(1'b1, 1'b1, "R10");
    for (int i = 1; i >= 0; i--) bitCycle(op[i], 1'b1, "R10");
    for (int i = 5; i >= 0; i--) bitCycle(a[i], 1'b1, "R10");
  endtask

  task automatic csLow();
    chipSel = 1'b0;
    serDin = 1'b0;
    tick(HALF);
    chk(serDout, 1'b1, "R10");
  endtask

  // program-type command; model updated from the requirements
  task automatic runCmd(input logic [1:0] op, input logic [5:0] a,
                        input logic [15:0] d, input int nData, input int lead);
    header(op, a, lead);
    for (int i = 0; i < nData; i++) bitCycle(d[15-i], 1'b1, "R10");
    csLow();
    case (op)
      2'b01: if (refEn && nData == 16) refMem[a] = d;
      2'b11: if (refEn) refMem[a] = 16'hFFFF;
      2'b00: case (a[5:4])
        2'b11: refEn = 1'b1;
        2'b00: refEn = 1'b0;
        2'b10: if (refEn) for (int k = 0; k < 64; k++) refMem[k] = 16'hFFFF;
        default: if (refEn && nData == 16) for (int k = 0; k < 64; k++) refMem[k] = d;
      endcase
      default: ;
    endcase
  endtask

  // read compared bit by bit; stopAt < 17 drops chip select mid-read
  task automatic readWord(input logic [5:0] a, input int lead, input int stopAt, input string req);
    header(2'b10, a, lead);
    for (int i = 0; i < 17 && i < stopAt; i++)
      bitCycle(1'b0, (i == 0) ? 1'b0 : refMem[a][16-i], req);
    if (stopAt >= 17) bitCycle(1'b0, 1'b1, "R10");
    csLow();
  endtask

  initial begin
    for (int k = 0; k < 64; k++) refMem[k] = 16'h0000;
    tick(3);
    chk(serDout, 1'b1, "R1");
    rstN = 1'b1;
    tick(3);
    chk(serDout, 1'b1, "R1");
    readWord(6'd0, 0, 17, "R1");
    readWord(6'd63, 0, 17, "R1");
    // R8: write and erase-all before enable have no effect
    runCmd(2'b01, 6'd5, 16'hA5A5, 16, 0);
    runCmd(2'b00, 6'b100000, 16'h0, 0, 0);
    readWord(6'd5, 0, 17, "R8");
    readWord(6'd9, 0, 17, "R8");
    // R8 enable with don't-care low bits, sent after R2 leading zeros
    runCmd(2'b00, 6'b111010, 16'h0, 0, 2);
    runCmd(2'b01, 6'd5, 16'h1234, 16, 0);
    runCmd(2'b01, 6'd63, 16'hBEEF, 16, 0);
    runCmd(2'b01, 6'd0, 16'h8001, 16, 1);
    readWord(6'd5, 0, 17, "R4");
    readWord(6'd63, 0, 17, "R4");
    readWord(6'd0, 3, 17, "R3");
    // R5 erase
    runCmd(2'b11, 6'd5, 16'h0, 0, 0);
    readWord(6'd5, 0, 17, "R5");
    // R9 partial write aborted, then partial read aborted
    runCmd(2'b01, 6'd63, 16'h0000, 7, 0);
    readWord(6'd63, 0, 17, "R9");
    readWord(6'd63, 0, 6, "R9");
    readWord(6'd0, 0, 17, "R9");
    // R6 erase-all
    runCmd(2'b00, 6'b100101, 16'h0, 0, 0);
    readWord(6'd0, 0, 17, "R6");
    readWord(6'd40, 0, 17, "R6");
    // R7 write-all
    runCmd(2'b00, 6'b010011, 16'h5AC3, 16, 0);
    readWord(6'd1, 0, 17, "R7");
    readWord(6'd63, 0, 17, "R7");
    // R8 disable then attempt every program command
    runCmd(2'b00, 6'b000111, 16'h0, 0, 0);
    runCmd(2'b01, 6'd2, 16'h0F0F, 16, 0);
    runCmd(2'b11, 6'd3, 16'h0, 0, 0);
    runCmd(2'b00, 6'b010000, 16'h1111, 16, 0);
    runCmd(2'b00, 6'b100000, 16'h0, 0, 0);
    readWord(6'd2, 0, 17, "R8");
    readWord(6'd3, 0, 17, "R8");
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule